// File: doc/BRIEF.md
# Next Program Counter Selector

This block owns the fetch address of a simple in-order processor. It keeps a 32-bit program counter in a register and, every clock, loads that register with one of four candidate addresses. A 2-bit select input picks the candidate. The candidates are the next sequential word, a branch target relative to the current instruction, an absolute target inside the current 256 MB region, and an address taken directly from a register operand.

Decode logic in front of the block supplies three inputs: the select code, the instruction word that holds the immediates, and the register operand. The decoder has already settled whether a branch is taken, so this block never evaluates a condition.

The block also drives two combinational outputs. The first is the address the counter will hold after the coming edge, which lets fetch look ahead. The second is the return address that call-type instructions write back to the register file. That return address points two instructions past the current one.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) loads the program counter with 0xBFC00000, whatever the other inputs are.
- R2: With select 2'b00, the counter advances by one 32-bit word: new value = old value + 4.
- R3: With select 2'b01, new value = old value + 4 + (instruction bits 15:0 sign-extended and multiplied by 4).
- R4: With select 2'b10, new value = {bits 31:28 of (old value + 4), instruction bits 25:0, 2'b00}.
- R5: With select 2'b11, new value = the register operand exactly as given. Unaligned low bits are kept.
- R6: `link_addr` always equals the current counter + 8, modulo 2^32.
- R7: `next_pc` shows, combinationally, the value the counter takes at the next edge when reset is not asserted. All address arithmetic wraps modulo 2^32.
- R8: The region jump takes its upper 4 bits from the incremented address, not from the current one. A jump issued from 0x0FFFFFFC therefore lands in region 0x1.
- R9: A negative branch offset moves the counter backwards. The most negative offset (bits 15:0 = 0x8000) moves it back by 131068 bytes from the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| nxt_sel | input | 2 | Next-address source: 0 step, 1 relative, 2 region, 3 register |
| instr_word | input | 32 | Current instruction word carrying the immediates |
| reg_operand | input | 32 | Register value used by the register jump |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded at the next edge |
| link_addr | output | 32 | Return address, program counter + 8 |

## Verification
The assertions assume that `nxt_sel`, `instr_word` and `reg_operand` hold known values that stay steady around each rising edge. They also assume that `rst_n` is low from time zero until the first edges have passed, so every comparison with the previous cycle starts from the reset vector. The stimulus holds reset low at start-up, changes every input only at a falling edge, and uses only defined 2-bit select codes. It also pulses reset once in mid-run while a register jump is selected. Directed steps move the counter next to region and address-space boundaries, where the wrap and region-bit cases occur; a stretch of pseudo-random vectors follows.

// File: rtl/pcseq_pkg.sv
// Package: shared select encoding for the next-address logic.
// Assumes the decoder produces exactly these 2-bit codes.
package pcseq_pkg;

    typedef enum logic [1:0] {
        SEL_STEP   = 2'd0,
        SEL_REL    = 2'd1,
        SEL_REGION = 2'd2,
        SEL_REGVAL = 2'd3
    } next_src_e;

endpackage

// File: rtl/pc_target_calc.sv
// Module: pc_target_calc
// Computes the candidate next addresses and the return address from the
// current counter and instruction. Purely combinational.
// Assumes word alignment is 2**ALIGN_SH bytes and that the immediates sit
// in the low bits of the instruction.
module pc_target_calc #(
    parameter int ADDR_W    = 32,
    parameter int INSTR_W   = 32,
    parameter int BR_IMM_W  = 16,
    parameter int JMP_IMM_W = 26,
    parameter int ALIGN_SH  = 2
) (
    input  logic [ADDR_W-1:0]  pc_cur,
    input  logic [INSTR_W-1:0] instr,
    output logic [ADDR_W-1:0]  step_tgt,
    output logic [ADDR_W-1:0]  rel_tgt,
    output logic [ADDR_W-1:0]  region_tgt,
    output logic [ADDR_W-1:0]  link_tgt
);
    localparam int REGION_W = ADDR_W - JMP_IMM_W - ALIGN_SH;
    localparam int EXT_W    = ADDR_W - BR_IMM_W - ALIGN_SH;
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1 << ALIGN_SH);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 << ALIGN_SH);

    logic [BR_IMM_W-1:0]  br_imm;
    logic [JMP_IMM_W-1:0] jmp_imm;
    logic [ADDR_W-1:0]    rel_off;
    logic                 unused_opcode_bits;

    assign br_imm             = instr[BR_IMM_W-1:0];
    assign jmp_imm            = instr[JMP_IMM_W-1:0];
    assign unused_opcode_bits = ^instr[INSTR_W-1:JMP_IMM_W];

    // Sequential and return addresses.
    always_comb begin
        step_tgt = pc_cur + STEP;
        link_tgt = pc_cur + STEP2;
    end

    // Relative target: sign-extend, scale to words, add to the step address.
    always_comb begin
        rel_off = {{EXT_W{br_imm[BR_IMM_W-1]}}, br_imm, {ALIGN_SH{1'b0}}};
        rel_tgt = step_tgt + rel_off;
    end

    // Region target: keep the region bits of the step address if any exist.
    generate
        if (REGION_W > 0) begin : g_region
            assign region_tgt = {step_tgt[ADDR_W-1 -: REGION_W], jmp_imm, {ALIGN_SH{1'b0}}};
        end else begin : g_flat
            assign region_tgt = ADDR_W'({jmp_imm, {ALIGN_SH{1'b0}}});
        end
    endgenerate

endmodule

// File: rtl/pc_next_mux.sv
// Module: pc_next_mux
// Picks the next counter value from the four candidates.
// Assumes the select is always a defined code.
module pc_next_mux
    import pcseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  next_src_e         sel,
    input  logic [ADDR_W-1:0] step_tgt,
    input  logic [ADDR_W-1:0] rel_tgt,
    input  logic [ADDR_W-1:0] region_tgt,
    input  logic [ADDR_W-1:0] reg_tgt,
    output logic [ADDR_W-1:0] nxt
);
    // Four-way select of the next address.
    always_comb begin
        unique case (sel)
            SEL_STEP:   nxt = step_tgt;
            SEL_REL:    nxt = rel_tgt;
            SEL_REGION: nxt = region_tgt;
            SEL_REGVAL: nxt = reg_tgt;
            default:    nxt = step_tgt;
        endcase
    end

endmodule

// File: rtl/pc_state_reg.sv
// Module: pc_state_reg
// Holds the program counter and applies the synchronous active-low reset.
// Assumes rst_n is synchronous to clk.
module pc_state_reg #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Load the reset vector or the chosen next address.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VEC;
        else        q <= d;
    end

endmodule

// File: rtl/pc_sequencer.sv
// Module: pc_sequencer (top)
// Program counter with four next-address sources and a return address output.
// Assumes the decoder has already resolved branch conditions into nxt_sel.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                INSTR_W   = 32,
    parameter int                BR_IMM_W  = 16,
    parameter int                JMP_IMM_W = 26,
    parameter int                ALIGN_SH  = 2,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         nxt_sel,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [ADDR_W-1:0]  reg_operand,
    output logic [ADDR_W-1:0]  pc_q,
    output logic [ADDR_W-1:0]  next_pc,
    output logic [ADDR_W-1:0]  link_addr
);
    logic [ADDR_W-1:0] step_tgt;
    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] region_tgt;
    next_src_e         sel_e;

    assign sel_e = next_src_e'(nxt_sel);

    pc_target_calc #(
        .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .BR_IMM_W(BR_IMM_W),
        .JMP_IMM_W(JMP_IMM_W), .ALIGN_SH(ALIGN_SH)
    ) u_calc (
        .pc_cur    (pc_q),
        .instr     (instr_word),
        .step_tgt  (step_tgt),
        .rel_tgt   (rel_tgt),
        .region_tgt(region_tgt),
        .link_tgt  (link_addr)
    );

    pc_next_mux #(.ADDR_W(ADDR_W)) u_mux (
        .sel       (sel_e),
        .step_tgt  (step_tgt),
        .rel_tgt   (rel_tgt),
        .region_tgt(region_tgt),
        .reg_tgt   (reg_operand),
        .nxt       (next_pc)
    );

    pc_state_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (next_pc),
        .q    (pc_q)
    );

endmodule

// File: rtl/pc_sequencer_checker.sv
// Module: pc_sequencer_checker
// Temporal checks on the program counter, attached to every pc_sequencer.
// Assumes reset is held low from time zero.
module pc_sequencer_checker #(
    parameter int                ADDR_W    = 32,
    parameter int                INSTR_W   = 32,
    parameter int                BR_IMM_W  = 16,
    parameter int                JMP_IMM_W = 26,
    parameter int                ALIGN_SH  = 2,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         nxt_sel,
    input logic [INSTR_W-1:0] instr_word,
    input logic [ADDR_W-1:0]  reg_operand,
    input logic [ADDR_W-1:0]  pc_q,
    input logic [ADDR_W-1:0]  next_pc,
    input logic [ADDR_W-1:0]  link_addr
);
    localparam int REGION_W = ADDR_W - JMP_IMM_W - ALIGN_SH;
    localparam int EXT_W    = ADDR_W - BR_IMM_W - ALIGN_SH;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN_SH);

    logic              started = 1'b0;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] br_off;
    logic              unused_chk_bits;

    assign pc_inc          = pc_q + STEP;
    assign br_off          = {{EXT_W{instr_word[BR_IMM_W-1]}}, instr_word[BR_IMM_W-1:0], {ALIGN_SH{1'b0}}};
    assign unused_chk_bits = ^instr_word[INSTR_W-1:JMP_IMM_W];

    // Marks that at least one edge has been seen.
    always_ff @(posedge clk) started <= 1'b1;

    assert_reset_vector_R1: assert property (@(posedge clk)
        started && !$past(rst_n) |-> pc_q == RESET_VEC);

    assert_step_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(nxt_sel) == 2'd0 |-> pc_q == $past(pc_q) + STEP);

    assert_rel_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(nxt_sel) == 2'd1 |-> pc_q == $past(pc_inc) + $past(br_off));

    assert_region_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(nxt_sel) == 2'd2 |->
            pc_q[ADDR_W-REGION_W-1:0] == {$past(instr_word[JMP_IMM_W-1:0]), {ALIGN_SH{1'b0}}});

    assert_region_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(nxt_sel) == 2'd2 |->
            pc_q[ADDR_W-1 -: REGION_W] == $past(pc_inc[ADDR_W-1 -: REGION_W]));

    assert_reg_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(nxt_sel) == 2'd3 |-> pc_q == $past(reg_operand));

    assert_link_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(nxt_sel) == 2'd0 |-> link_addr == $past(link_addr) + STEP);

    assert_next_commits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc_q == $past(next_pc));

endmodule

bind pc_sequencer pc_sequencer_checker #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .BR_IMM_W(BR_IMM_W),
    .JMP_IMM_W(JMP_IMM_W), .ALIGN_SH(ALIGN_SH), .RESET_VEC(RESET_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nxt_sel    (nxt_sel),
    .instr_word (instr_word),
    .reg_operand(reg_operand),
    .pc_q       (pc_q),
    .next_pc    (next_pc),
    .link_addr  (link_addr)
);

// File: tb/pc_sequencer_test.sv
// Bench: behavioural reference model, compared every cycle at the falling edge.
module pc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  nxt_sel = 2'd0;
    logic [31:0] instr_word = 32'd0;
    logic [31:0] reg_operand = 32'd0;
    logic [31:0] pc_q, next_pc, link_addr;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] model_pc = 32'hBFC0_0000;
    string last_tag = "R1";

    always #5 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .nxt_sel(nxt_sel), .instr_word(instr_word),
        .reg_operand(reg_operand), .pc_q(pc_q), .next_pc(next_pc), .link_addr(link_addr)
    );

    // Reference next-address rule, written from the requirements.
    function automatic logic [31:0] ref_next(logic [31:0] pc, logic [1:0] s,
                                             logic [31:0] iw, logic [31:0] rv);
        int off;
        case (s)
            2'd0: return pc + 32'd4;
            2'd1: begin
                off = int'($signed(iw[15:0])) * 4;
                return pc + 32'd4 + 32'(off);
            end
            2'd2: return ((pc + 32'd4) & 32'hF000_0000) | (32'(iw[25:0]) * 32'd4);
            default: return rv;
        endcase
    endfunction

    task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: check state, drive inputs, check lookahead, advance model.
    task automatic step(logic r, logic [1:0] s, logic [31:0] iw, logic [31:0] rv, string tag);
        compare(last_tag, pc_q, model_pc);
        compare("R6", link_addr, model_pc + 32'd8);
        rst_n = r; nxt_sel = s; instr_word = iw; reg_operand = rv;
        #1;
        compare("R7", next_pc, ref_next(model_pc, s, iw, rv));
        @(posedge clk);
        model_pc = r ? ref_next(model_pc, s, iw, rv) : 32'hBFC0_0000;
        last_tag = r ? tag : "R1";
        @(negedge clk);
    endtask

    function automatic string sel_tag(logic [1:0] s);
        case (s)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [1:0] rs;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state, held with other inputs nonzero
        step(1'b0, 2'd3, 32'hFFFF_FFFF, 32'h1234_5678, "R1");
        step(1'b1, 2'd0, 32'd0, 32'd0, "R2");
        step(1'b1, 2'd0, 32'd0, 32'd0, "R2");
        step(1'b1, 2'd1, 32'h0000_0010, 32'd0, "R3");
        step(1'b1, 2'd1, 32'h0000_FFFC, 32'd0, "R9");
        step(1'b1, 2'd1, 32'hABCD_8000, 32'd0, "R9");
        step(1'b1, 2'd2, 32'h0812_3456, 32'd0, "R4");
        step(1'b1, 2'd3, 32'd0, 32'h0FFF_FFFC, "R5");
        step(1'b1, 2'd2, 32'h0000_0123, 32'd0, "R8");
        step(1'b1, 2'd3, 32'd0, 32'h0000_0003, "R5");
        step(1'b1, 2'd0, 32'd0, 32'd0, "R2");
        step(1'b1, 2'd3, 32'd0, 32'hFFFF_FFFC, "R5");
        step(1'b1, 2'd0, 32'd0, 32'd0, "R7");
        step(1'b1, 2'd1, 32'h0000_7FFF, 32'd0, "R3");
        // mid-run reset with a register jump requested
        step(1'b0, 2'd3, 32'd0, 32'h0000_4000, "R1");
        step(1'b1, 2'd0, 32'd0, 32'd0, "R2");
        for (int i = 0; i < 400; i++) begin
            rs = 2'($urandom_range(0, 3));
            step(1'b1, rs, $urandom, $urandom, sel_tag(rs));
        end
        compare(last_tag, pc_q, model_pc);
        compare("R6", link_addr, model_pc + 32'd8);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule